// File: doc/BRIEF.md
# Banked ROM Address Decoder

This block sits between an 8-bit processor's 16-bit address bus and the memories and peripherals around it. From the address, the read/write flag and a service-door input it produces combinational chip selects for the ROM, the RAM and the on-board I/O page, and a strobe for a separate peripheral board. The RAM has a top window of 512 bytes that holds settings. Writes to that window reach the RAM only while the service door is open. Reads of the window are never blocked.

The ROM is larger than the processor can see at one time. A 5-bit page register supplies the upper ROM address bits, and the processor's low 14 address bits pass straight through. The processor changes the page by writing to the page-select address in the I/O page. Each such write also gives a single-cycle pulse on the page-select strobe, so the strobe can feed a supervision timer. For this reason a write of the value already held still gives the pulse.

All decode outputs are combinational. Only the page register and its strobe are clocked. There is no data stream, so the pins are plain control signals with no valid/ready handshake and no back-pressure.

Top module: `rom_bank_decoder`

## Requirements
- R1: `rom_sel` is 1 exactly when address bit 15 or bit 14 is 1 (0x4000 to 0xFFFF).
- R2: When bits 15, 14 and 13 are all 0 (0x0000 to 0x1FFF), `ram_sel` is 1 for any read (`rd_wr`=1). It is also 1 for any write (`rd_wr`=0) below 0x1E00.
- R3: For a write (`rd_wr`=0) to 0x1E00 to 0x1FFF (bits 12 to 9 all 1), `ram_sel` follows `door_open`. It is 1 when the door is open and 0 when it is closed.
- R4: `board_stb` is 1 exactly when bits 15 and 14 are 0, bit 13 is 1 and bit 11 is 0. Bit 12 is not decoded.
- R5: `io_sel` is 1 exactly when bits 15 to 11 equal 00110 (0x3000 to 0x37FF).
- R6: At most one of `rom_sel`, `ram_sel` and `io_sel` is 1 at any time.
- R7: `rom_addr[18:14]` equals the page register and `rom_addr[13:0]` equals `addr[13:0]`.
- R8: A write access is the first clock cycle in which `wr_stb` is 1 while `rd_wr` is 0. A write access whose address bits 15 to 8 equal 0x32 loads `wdata[4:0]` into the page register at that clock edge. `bank_stb` is 1 for exactly the next cycle.
- R9: A page-select write of the value already held still gives the one-cycle `bank_stb` pulse.
- R10: Holding `wr_stb` high for several cycles counts as one write access. Reads, and writes to any other address, leave the page register unchanged and give no `bank_stb`.
- R11: After reset the page register is 0 and `bank_stb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 16 | Processor address bus |
| rd_wr | input | 1 | 1 for read, 0 for write |
| wr_stb | input | 1 | Write strobe; its first high cycle marks the access |
| wdata | input | 8 | Processor write data |
| door_open | input | 1 | 1 while the service door is open |
| rom_sel | output | 1 | ROM chip select |
| ram_sel | output | 1 | RAM chip select |
| io_sel | output | 1 | On-board I/O page select |
| board_stb | output | 1 | Peripheral-board strobe |
| rom_addr | output | 19 | Banked ROM address |
| bank_stb | output | 1 | One-cycle pulse after each page-select write |

## Verification
The decode is swept over every 256-byte page, each with a varying low byte. The sweep uses all four combinations of read or write and door open or closed. This separates the regions that depend on the address alone from the protected window, whose select depends on direction and door state. The window edges 0x1DFF and 0x1E00 are tried on their own. The 0x3000 page shows the peripheral strobe coinciding with the I/O select. For the page register, the bench tries a new value, a repeat of the same value and a held strobe. It also tries a read and a write to a neighbouring I/O address. Each result is watched through `rom_addr` and `bank_stb`, which tells a real load apart from a spurious one or a doubled one.

// File: rtl/rom_dec_pkg.sv
package rom_dec_pkg;
  parameter int ADDR_W = 16;
  parameter int DATA_W = 8;
  parameter int BANK_W = 5;
  parameter int OFFS_W = 14;
  localparam int ROM_AW = BANK_W + OFFS_W;

  typedef struct packed {
    logic rom;
    logic ram;
    logic io;
    logic board;
  } sel_t;
endpackage

// File: rtl/addr_region_dec.sv
module addr_region_dec
  import rom_dec_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  input  logic          rd_wr,
  input  logic          door_open,
  output sel_t          sel,
  output logic          bank_hit
);
  localparam int T = AW - 1;

  logic low_8k;
  logic prot_win;
  logic upper_zero;

  always_comb begin
    upper_zero = ~addr[T] & ~addr[T-1];
    low_8k     = upper_zero & ~addr[T-2];
    prot_win   = addr[T-3] & addr[T-4] & addr[T-5] & addr[T-6];

    sel.rom   = addr[T] | addr[T-1];
    sel.ram   = low_8k & (~prot_win | rd_wr | door_open);
    sel.io    = upper_zero & addr[T-2] & addr[T-3] & ~addr[T-4];
    sel.board = upper_zero & addr[T-2] & ~addr[T-4];
    bank_hit  = sel.io & (addr[T-5:T-7] == 3'b010);
  end
endmodule

// File: rtl/bank_page_reg.sv
module bank_page_reg
  import rom_dec_pkg::*;
#(
  parameter int BW = BANK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          hit,
  input  logic [BW-1:0] din,
  output logic [BW-1:0] page,
  output logic          stb
);
  logic req_q;
  logic load;

  assign load = wr_req & ~req_q & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      page  <= '0;
      stb   <= 1'b0;
    end else begin
      req_q <= wr_req;
      stb   <= load;
      if (load) page <= din;
    end
  end

  // R8
  stb_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);

  // R8
  page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (stb && page == $past(din)));

  // R10
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(page) && !stb));
endmodule

// File: rtl/rom_bank_decoder.sv
module rom_bank_decoder
  import rom_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_wr,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic              door_open,
  output logic              rom_sel,
  output logic              ram_sel,
  output logic              io_sel,
  output logic              board_stb,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              bank_stb
);
  sel_t              sel;
  logic              bank_hit;
  logic [BANK_W-1:0] page;

  addr_region_dec #(.AW(ADDR_W)) u_dec (
    .addr      (addr),
    .rd_wr     (rd_wr),
    .door_open (door_open),
    .sel       (sel),
    .bank_hit  (bank_hit)
  );

  bank_page_reg #(.BW(BANK_W)) u_page (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_req (wr_stb & ~rd_wr),
    .hit    (bank_hit),
    .din    (wdata[BANK_W-1:0]),
    .page   (page),
    .stb    (bank_stb)
  );

  assign rom_sel   = sel.rom;
  assign ram_sel   = sel.ram;
  assign io_sel    = sel.io;
  assign board_stb = sel.board;
  assign rom_addr  = {page, addr[OFFS_W-1:0]};

  // R6
  sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_sel, ram_sel, io_sel}));

  // R3
  prot_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_wr && !door_open && addr[15:9] == 7'b0001111) |-> !ram_sel);

  // R1
  rom_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[15:14] != 2'b00) |-> (rom_sel && !board_stb));

  // R7
  rom_offs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_addr[OFFS_W-1:0] == addr[OFFS_W-1:0]);
endmodule

// File: tb/test_rom_bank_decoder.sv
module test_rom_bank_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0;
  logic        rd_wr = 1'b1;
  logic        wr_stb = 1'b0;
  logic [7:0]  wdata = 8'h0;
  logic        door_open = 1'b0;
  logic        rom_sel, ram_sel, io_sel, board_stb, bank_stb;
  logic [18:0] rom_addr;

  int n_cmp = 0;
  int n_bad = 0;
  logic [4:0] exp_page = 5'd0;

  always #2 clk = ~clk;

  rom_bank_decoder i_rom_bank_decoder (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_wr(rd_wr), .wr_stb(wr_stb),
    .wdata(wdata), .door_open(door_open), .rom_sel(rom_sel), .ram_sel(ram_sel),
    .io_sel(io_sel), .board_stb(board_stb), .rom_addr(rom_addr), .bank_stb(bank_stb)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (addr %h)", req, act, exp, addr);
    end
  endtask

  function automatic logic e_rom(input logic [15:0] a);
    return a >= 16'h4000;
  endfunction
  function automatic logic e_ram(input logic [15:0] a, input logic rw, input logic door);
    if (a >= 16'h2000) return 1'b0;
    if (a < 16'h1E00 || rw) return 1'b1;
    return door;
  endfunction
  function automatic logic e_io(input logic [15:0] a);
    return a >= 16'h3000 && a <= 16'h37FF;
  endfunction
  function automatic logic e_brd(input logic [15:0] a);
    return (a >= 16'h2000 && a <= 16'h27FF) || (a >= 16'h3000 && a <= 16'h37FF);
  endfunction

  task automatic check_decode();
    chk("R1", rom_sel, e_rom(addr));
    if (addr[15:9] == 7'b0001111 && !rd_wr) chk("R3", ram_sel, e_ram(addr, rd_wr, door_open));
    else chk("R2", ram_sel, e_ram(addr, rd_wr, door_open));
    chk("R5", io_sel, e_io(addr));
    chk("R4", board_stb, e_brd(addr));
    chk("R6", (32'(rom_sel) + 32'(ram_sel) + 32'(io_sel)) <= 1, 1);
    chk("R7", rom_addr, {exp_page, addr[13:0]});
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R11", bank_stb, 0);
    chk("R11", rom_addr[18:14], 0);
  endtask

  task automatic t_sweep();
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 256; p++) begin
        @(negedge clk);
        rd_wr = m[0]; door_open = m[1];
        addr = {p[7:0], 8'(p * 37 + 11)};
        #1 check_decode();
      end
    end
  endtask

  task automatic t_window_edges();
    rd_wr = 1'b0; door_open = 1'b0;
    @(negedge clk); addr = 16'h1DFF; #1 chk("R2", ram_sel, 1);
    @(negedge clk); addr = 16'h1E00; #1 chk("R3", ram_sel, 0);
    @(negedge clk); addr = 16'h1FFF; #1 chk("R3", ram_sel, 0);
    door_open = 1'b1;
    @(negedge clk); #1 chk("R3", ram_sel, 1);
    door_open = 1'b0; rd_wr = 1'b1;
    @(negedge clk); #1 chk("R2", ram_sel, 1);
    @(negedge clk); addr = 16'h3000; #1 chk("R4", board_stb, 1); chk("R5", io_sel, 1);
    @(negedge clk); addr = 16'h2800; #1 chk("R4", board_stb, 0);
  endtask

  task automatic bus_write(input logic [15:0] a, input logic rw, input logic [7:0] d,
                           input int hold, input logic exp_load, input string req);
    @(negedge clk);
    addr = a; rd_wr = rw; wdata = d; wr_stb = 1'b1;
    if (exp_load) exp_page = d[4:0];
    @(negedge clk);
    chk(req, bank_stb, exp_load);
    chk(req, rom_addr[18:14], exp_page);
    for (int k = 1; k < hold; k++) begin
      @(negedge clk);
      chk(req, bank_stb, 0);
      chk(req, rom_addr[18:14], exp_page);
    end
    wr_stb = 1'b0; rd_wr = 1'b1;
    @(negedge clk);
    chk(req, bank_stb, 0);
    chk("R7", rom_addr, {exp_page, addr[13:0]});
  endtask

  task automatic t_bank();
    bus_write(16'h3200, 1'b0, 8'h13, 1, 1'b1, "R8");
    bus_write(16'h3200, 1'b0, 8'h13, 1, 1'b1, "R9");
    bus_write(16'h32A5, 1'b0, 8'hE6, 3, 1'b1, "R10");
    bus_write(16'h3200, 1'b1, 8'h01, 1, 1'b0, "R10");
    bus_write(16'h3300, 1'b0, 8'h02, 1, 1'b0, "R10");
    bus_write(16'h1200, 1'b0, 8'h03, 1, 1'b0, "R10");
    bus_write(16'h3200, 1'b0, 8'h00, 1, 1'b1, "R9");
    bus_write(16'h3200, 1'b0, 8'h00, 1, 1'b1, "R9");
    @(negedge clk); addr = 16'hC123; #1 chk("R7", rom_addr, {5'd0, 14'h0123});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sweep();
    t_window_edges();
    t_bank();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule